// File: doc/BRIEF.md
# RV64 Word-Operation ALU

This execution unit handles the word-sized integer operations of a 64-bit processor. These are add-immediate-word, add-word and subtract-word, plus logical left, logical right and arithmetic right shifts. Each shift comes in a register form and an immediate form. Every operation reads only the low 32 bits of its operands and computes a 32-bit result. Any carry out of bit 31 is lost. The 32-bit result is then widened to 64 bits by copying bit 31 into the upper half.

An issue stage presents both source register values, a 12-bit immediate, a 5-bit shift amount, an operation code and a valid strobe. The unit registers the result on the next clock edge. It raises its output valid on that same edge. The result register loads only when the input is valid, so the last result stays on the output between issues.

Top module: `word_alu`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is 0.
- R2: valid_o equals the valid_i sampled at the previous rising clock edge, and result_o shows the result of the operation issued at that edge.
- R3: result_o[63:32] always equals 32 copies of result_o[31].
- R4: Add-immediate-word (op_i = 0) adds imm_i, sign-extended from bit 11, to rs1_i[31:0] modulo 2^32. With imm_i = 0 the result is rs1_i[31:0] sign-extended.
- R5: Add-word (op_i = 1) and subtract-word (op_i = 2, rs1 minus rs2) wrap modulo 2^32 and ignore overflow.
- R6: Register shifts take their amount from rs2_i[4:0] only: left logical (op_i = 3), right logical (op_i = 4) and right arithmetic (op_i = 5). Bits rs2_i[63:5] have no effect.
- R7: Immediate shifts take their amount from shamt_i and do not use rs2_i: left logical (op_i = 6), right logical (op_i = 7) and right arithmetic (op_i = 8).
- R8: Right arithmetic shifts fill vacated bits with rs1_i[31]. Right logical shifts fill with zeros. rs1_i[63:32] never affects any result.
- R9: When valid_i is low at a clock edge, result_o keeps its value through that edge.
- R10: An op_i value from 9 to 15 yields a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Operation code (see R4 to R10) |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand |
| imm_i | input | 12 | Immediate for add-immediate-word |
| shamt_i | input | 5 | Shift amount for immediate shifts |
| result_o | output | 64 | Registered, sign-extended word result |
| valid_o | output | 1 | Registered valid |

## Verification
The adds are tried with carries that cross bit 31, a negative immediate, a zero immediate and operands that have junk in the upper half. These cases separate wrap-around and sign extension from full-width arithmetic. The shifts are tried with amounts of 0, 1, 4, 28, 30 and 31, and with rs2 values whose upper bits are set. These cases show that only five amount bits count, and that fill comes from bit 31 rather than bit 63. Undefined codes, idle cycles and a reset mid-run cover the hold and clear paths.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADDIW = 4'd0,
    OP_ADDW  = 4'd1,
    OP_SUBW  = 4'd2,
    OP_SLLW  = 4'd3,
    OP_SRLW  = 4'd4,
    OP_SRAW  = 4'd5,
    OP_SLLIW = 4'd6,
    OP_SRLIW = 4'd7,
    OP_SRAIW = 4'd8
  } word_op_e;

  localparam int unsigned LAST_OP = 8;
endpackage

// File: rtl/wop_decode.sv
module wop_decode
  import word_alu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned WLEN    = 32,
  parameter int unsigned IMM_W   = 12,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [3:0]         op_i,
  input  logic [XLEN-1:0]    rs2_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [WLEN-1:0]    opnd_b_o,
  output logic [SHAMT_W-1:0] amt_o,
  output logic               sub_o,
  output logic               shift_o,
  output logic               left_o,
  output logic               arith_o,
  output logic               legal_o
);
  logic [WLEN-1:0] imm_ext;
  logic            use_imm_amt;
  logic            use_imm_b;

  assign imm_ext = {{(WLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    sub_o       = 1'b0;
    shift_o     = 1'b0;
    left_o      = 1'b0;
    arith_o     = 1'b0;
    legal_o     = 1'b1;
    use_imm_amt = 1'b0;
    use_imm_b   = 1'b0;
    unique case (op_i)
      OP_ADDIW: use_imm_b = 1'b1;
      OP_ADDW:  ;
      OP_SUBW:  sub_o = 1'b1;
      OP_SLLW:  begin shift_o = 1'b1; left_o = 1'b1; end
      OP_SRLW:  shift_o = 1'b1;
      OP_SRAW:  begin shift_o = 1'b1; arith_o = 1'b1; end
      OP_SLLIW: begin shift_o = 1'b1; left_o = 1'b1; use_imm_amt = 1'b1; end
      OP_SRLIW: begin shift_o = 1'b1; use_imm_amt = 1'b1; end
      OP_SRAIW: begin shift_o = 1'b1; arith_o = 1'b1; use_imm_amt = 1'b1; end
      default:  legal_o = 1'b0;
    endcase
  end

  assign opnd_b_o = use_imm_b ? imm_ext : rs2_i[WLEN-1:0];
  // register form keeps only the low amount bits of rs2
  assign amt_o    = use_imm_amt ? shamt_i : rs2_i[SHAMT_W-1:0];
endmodule

// File: rtl/wop_adder.sv
module wop_adder #(
  parameter int unsigned WLEN = 32
) (
  input  logic [WLEN-1:0] a_i,
  input  logic [WLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [WLEN-1:0] sum_o
);
  logic [WLEN-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  // carry out of the top bit is dropped
  assign sum_o = a_i + b_eff + {{(WLEN-1){1'b0}}, sub_i};
endmodule

// File: rtl/wop_shifter.sv
module wop_shifter #(
  parameter int unsigned WLEN    = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [WLEN-1:0]    a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [WLEN-1:0]    res_o
);
  logic [WLEN-1:0] a_rev;
  logic [WLEN-1:0] out_rev;
  logic [WLEN-1:0] stage [SHAMT_W+1];
  logic            fill;

  // left shift = right shift of the bit-reversed word
  for (genvar i = 0; i < WLEN; i++) begin : g_rev
    assign a_rev[i]   = a_i[WLEN-1-i];
    assign out_rev[i] = stage[SHAMT_W][WLEN-1-i];
  end

  assign fill     = arith_i & ~left_i & a_i[WLEN-1];
  assign stage[0] = left_i ? a_rev : a_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{SH{fill}}, stage[s][WLEN-1:SH]} : stage[s];
  end

  assign res_o = left_i ? out_rev : stage[SHAMT_W];
endmodule

// File: rtl/word_alu.sv
module word_alu
  import word_alu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned WLEN    = 32,
  parameter int unsigned IMM_W   = 12,
  parameter int unsigned SHAMT_W = $clog2(WLEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [3:0]         op_i,
  input  logic [XLEN-1:0]    rs1_i,
  input  logic [XLEN-1:0]    rs2_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [XLEN-1:0]    result_o,
  output logic               valid_o
);
  localparam int unsigned EXT_W = XLEN - WLEN;

  logic [WLEN-1:0]    opnd_b, sum, shres, word;
  logic [SHAMT_W-1:0] amt;
  logic               sub, shift, left, arith, legal;
  logic               unused_hi;

  assign unused_hi = ^rs1_i[XLEN-1:WLEN];

  wop_decode #(
    .XLEN(XLEN), .WLEN(WLEN), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
  ) u_dec (
    .op_i(op_i), .rs2_i(rs2_i), .imm_i(imm_i), .shamt_i(shamt_i),
    .opnd_b_o(opnd_b), .amt_o(amt), .sub_o(sub), .shift_o(shift),
    .left_o(left), .arith_o(arith), .legal_o(legal)
  );

  wop_adder #(.WLEN(WLEN)) u_add (
    .a_i(rs1_i[WLEN-1:0]), .b_i(opnd_b), .sub_i(sub), .sum_o(sum)
  );

  wop_shifter #(.WLEN(WLEN), .SHAMT_W(SHAMT_W)) u_shf (
    .a_i(rs1_i[WLEN-1:0]), .amt_i(amt), .left_i(left), .arith_i(arith),
    .res_o(shres)
  );

  always_comb begin
    if (!legal)     word = '0;
    else if (shift) word = shres;
    else            word = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= {{EXT_W{word[WLEN-1]}}, word};
    end
  end
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk
  import word_alu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned WLEN    = 32,
  parameter int unsigned IMM_W   = 12,
  parameter int unsigned SHAMT_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [3:0]         op_i,
  input logic [XLEN-1:0]    rs1_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic [XLEN-1:0]    result_o,
  input logic               valid_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (valid_o == 1'b0 && result_o == '0)
        else $error("reset state not clear");
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  p_upper_sext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}});

  p_addiw_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && op_i == OP_ADDIW && imm_i == '0)) |->
      result_o == {{(XLEN-WLEN){$past(rs1_i[WLEN-1])}}, $past(rs1_i[WLEN-1:0])});

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> $stable(result_o));

  p_undef_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && op_i > 4'(LAST_OP))) |-> result_o == '0);
endmodule

bind word_alu word_alu_chk #(
  .XLEN(XLEN), .WLEN(WLEN), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
) u_word_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .rs1_i(rs1_i), .imm_i(imm_i), .result_o(result_o), .valid_o(valid_o)
);

// File: tb/word_alu_bench.sv
module word_alu_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 20;

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] rs1;
    logic [63:0] rs2;
    logic [11:0] imm;
    logic [4:0]  sh;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 64'h0000000000000005, 64'h0, 12'h003, 5'd0, 64'h0000000000000008},
    '{4'd0, 64'hFFFFFFFF00000001, 64'h0, 12'hFFF, 5'd0, 64'h0000000000000000},
    '{4'd0, 64'h1234567880000000, 64'h0, 12'h000, 5'd0, 64'hFFFFFFFF80000000},
    '{4'd0, 64'h000000007FFFFFFF, 64'h0, 12'h001, 5'd0, 64'hFFFFFFFF80000000},
    '{4'd1, 64'h000000007FFFFFFF, 64'h1, 12'h000, 5'd0, 64'hFFFFFFFF80000000},
    '{4'd1, 64'hFFFFFFFFFFFFFFFF, 64'h1, 12'h000, 5'd0, 64'h0000000000000000},
    '{4'd2, 64'h0000000000000000, 64'h1, 12'h000, 5'd0, 64'hFFFFFFFFFFFFFFFF},
    '{4'd2, 64'h0000000080000000, 64'h1, 12'h000, 5'd0, 64'h000000007FFFFFFF},
    '{4'd3, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFE1, 12'h0, 5'd0, 64'h0000000000000002},
    '{4'd3, 64'h0000000000000001, 64'd31, 12'h0, 5'd0, 64'hFFFFFFFF80000000},
    '{4'd4, 64'hFFFFFFFF80000000, 64'd4, 12'h0, 5'd0, 64'h0000000008000000},
    '{4'd4, 64'h0000000080000000, 64'd0, 12'h0, 5'd0, 64'hFFFFFFFF80000000},
    '{4'd5, 64'h0000000080000000, 64'd4, 12'h0, 5'd0, 64'hFFFFFFFFF8000000},
    '{4'd5, 64'hFFFFFFFF7FFFFFFF, 64'h24, 12'h0, 5'd0, 64'h0000000007FFFFFF},
    '{4'd6, 64'h0000000000000003, 64'hFFFFFFFFFFFFFFFF, 12'h0, 5'd30, 64'hFFFFFFFFC0000000},
    '{4'd7, 64'h00000000F0000000, 64'd1, 12'h0, 5'd28, 64'h000000000000000F},
    '{4'd8, 64'h00000000F0000000, 64'd1, 12'h0, 5'd28, 64'hFFFFFFFFFFFFFFFF},
    '{4'd8, 64'h0000000040000000, 64'd0, 12'h0, 5'd31, 64'h0000000000000000},
    '{4'd9, 64'hFFFFFFFFFFFFFFFF, 64'h1, 12'h7FF, 5'd3, 64'h0000000000000000},
    '{4'd15, 64'h0000000012345678, 64'h1, 12'h001, 5'd1, 64'h0000000000000000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] rs1_i = '0, rs2_i = '0;
  logic [11:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  word_alu u_word_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .shamt_i(shamt_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:             return "R4";
      4'd1, 4'd2:       return "R5";
      4'd3, 4'd4, 4'd5: return "R6/R8";
      4'd6, 4'd7, 4'd8: return "R7/R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid", {63'd0, valid_o}, 64'd0);
    check("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: drive at negedge, result visible after one rising edge
    for (int k = 0; k < NVEC; k++) begin
      valid_i = 1'b1;
      op_i    = VECS[k].op;
      rs1_i   = VECS[k].rs1;
      rs2_i   = VECS[k].rs2;
      imm_i   = VECS[k].imm;
      shamt_i = VECS[k].sh;
      @(negedge clk_i);
      check(tag_of(VECS[k].op), result_o, VECS[k].exp);
      check("R2 valid_o", {63'd0, valid_o}, 64'd1);
      check("R3 upper", {32'd0, result_o[63:32]}, {32'd0, {32{result_o[31]}}});
    end

    // R9: idle cycle with new operands must not move the result
    valid_i = 1'b1; op_i = 4'd1; rs1_i = 64'd40; rs2_i = 64'd2;
    @(negedge clk_i);
    check("R5 add", result_o, 64'd42);
    valid_i = 1'b0; op_i = 4'd2; rs1_i = 64'd0; rs2_i = 64'd7;
    @(negedge clk_i);
    check("R9 hold", result_o, 64'd42);
    check("R2 valid low", {63'd0, valid_o}, 64'd0);
    @(negedge clk_i);
    check("R9 hold2", result_o, 64'd42);

    // R7: immediate shift ignores rs2 entirely
    valid_i = 1'b1; op_i = 4'd6; rs1_i = 64'h1; rs2_i = 64'h5; shamt_i = 5'd1;
    @(negedge clk_i);
    check("R7 shamt only", result_o, 64'd2);

    // R1: asynchronous reset mid-run
    valid_i = 1'b0;
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    check("R1 async result", result_o, 64'd0);
    check("R1 async valid", {63'd0, valid_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", result_o, 64'd0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule